// File: doc/BRIEF.md
# Strided Vector Address Generator with Bank Scoreboard

This block turns one vector memory request (a base word address, a stride and an element count) into a stream of single-word accesses. Element i goes to word `base + i*stride`, wrapped to the address width. Memory is split across 16 interleaved banks. The low four address bits choose the bank, and the remaining upper bits give the word within that bank.

A bank that has just been accessed needs four cycles to recover. A small timer per bank records this, and the stream waits in element order whenever the next element's bank is still recovering. Throughput therefore depends on the stride. An odd stride, or unit stride, runs at one access per cycle. A stride that is a multiple of 16 lands on the same bank every time and issues once every four cycles.

Memory returns read data a fixed 12 cycles after each access. The block tags each returning word with its element index, so the consumer sees data in element order. A one-cycle completion pulse goes out together with the last data word.

Top module: `vec_stride_agu`

## Requirements
- R1: The k-th access of a vector (k counted from 0) targets word address `(base + k*stride) mod 2^16`, where `base` and `stride` are captured at the accepted start.
- R2: The address of an access is presented split in two parts: `mem_bank` carries address bits [3:0], and `mem_row` carries address bits [15:4].
- R3: Two accesses to the same bank are at least 4 cycles apart, so in cycles t and t+1, t+2 or t+3 the bank is never repeated.
- R4: Accesses leave in strictly increasing element order with no element skipped. `mem_elem` is 0 for the first access and increases by one on each following access.
- R5: When no bank repeats within any 4 consecutive elements (for example strides 1, 2, 3 and 4), the accesses of a vector occupy consecutive cycles.
- R6: With a stride whose low four bits are zero, consecutive accesses of a vector are exactly 4 cycles apart.
- R7: For an access presented in cycle t, the value on `mem_rdata` in cycle t+12 appears on `rsp_data` in cycle t+13. In that cycle `rsp_vld` is high and `rsp_idx` equals that access's element index.
- R8: The number of accesses per vector equals `vlen`, and a `vlen` above 64 is treated as 64.
- R9: `done` is a single-cycle pulse that coincides with the response of the last element.
- R10: A start with `vlen` = 0 raises `done` in the next cycle and produces no access.
- R11: A start pulse that arrives while a vector is still in progress is ignored, and the running vector continues unchanged.
- R12: During and immediately after reset, `mem_vld`, `rsp_vld` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector; accepted only when idle |
| base | input | 16 | First word address |
| stride | input | 16 | Address increment between elements (two's complement wrap) |
| vlen | input | 7 | Element count, 0 to 64 (larger values clamp) |
| mem_vld | output | 1 | Access strobe to the banked memory |
| mem_bank | output | 4 | Bank of the access (address bits 3:0) |
| mem_row | output | 12 | Word within the bank (address bits 15:4) |
| mem_elem | output | 6 | Element index of the access |
| mem_rdata | input | 32 | Read data from memory, valid 12 cycles after the access |
| rsp_vld | output | 1 | Response strobe |
| rsp_idx | output | 6 | Element index of the response |
| rsp_data | output | 32 | Returned word |
| done | output | 1 | Pulse with the final response, or one cycle after a zero-length start |

## Verification
The order and spacing assertions assume that a new vector begins only after the previous one has signalled `done`, so a fresh element 0 never follows the old stream within one cycle. The stimulus waits for `done` before every new start. Its only start pulse during a running vector checks that such a pulse is dropped. The assertions also assume that memory answers every access exactly 12 cycles later. The bench's memory model is a 12-cycle delay line fed by the block's own access addresses, which guarantees this.

// File: rtl/vec_stride_agu.sv
module vec_stride_agu #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int BANK_BITS = 4,
  parameter int BUSY      = 4,
  parameter int LAT       = 12,
  parameter int MAXVL     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [AW-1:0]          base,
  input  logic [AW-1:0]          stride,
  input  logic [$clog2(MAXVL+1)-1:0] vlen,
  output logic                   mem_vld,
  output logic [BANK_BITS-1:0]   mem_bank,
  output logic [AW-BANK_BITS-1:0] mem_row,
  output logic [$clog2(MAXVL)-1:0] mem_elem,
  input  logic [DW-1:0]          mem_rdata,
  output logic                   rsp_vld,
  output logic [$clog2(MAXVL)-1:0] rsp_idx,
  output logic [DW-1:0]          rsp_data,
  output logic                   done
);
  localparam int NB  = 1 << BANK_BITS;
  localparam int VLW = $clog2(MAXVL+1);
  localparam int IW  = $clog2(MAXVL);
  localparam int TW  = $clog2(BUSY+1);
  localparam logic [TW-1:0]  RELOAD = TW'(BUSY-1);
  localparam logic [VLW-1:0] VLMAX  = VLW'(MAXVL);

  logic            act;
  logic [VLW-1:0]  len_q, idx_q;
  logic [AW-1:0]   addr_q, step_q;
  logic [TW-1:0]   tmr [NB];
  logic [LAT-1:0]  pv;
  logic [IW-1:0]   pidx [LAT];

  wire [BANK_BITS-1:0] cur_bank = addr_q[BANK_BITS-1:0];
  wire bank_free = (tmr[cur_bank] == '0);
  wire go        = act && (idx_q != len_q) && bank_free;
  wire accept    = start && !act;
  wire [VLW-1:0] len_in = (vlen > VLMAX) ? VLMAX : vlen;
  wire last_rsp  = act && pv[LAT-1] && (VLW'(pidx[LAT-1]) == len_q - VLW'(1));

  genvar b;
  generate
    for (b = 0; b < NB; b++) begin : g_bank
      always_ff @(posedge clk) begin
        if (!rst_n)                                tmr[b] <= '0;
        else if (go && cur_bank == BANK_BITS'(b))  tmr[b] <= RELOAD;
        else if (tmr[b] != '0)                     tmr[b] <= tmr[b] - TW'(1);
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= 1'b0;
      len_q  <= '0;
      idx_q  <= '0;
      addr_q <= '0;
      step_q <= '0;
    end else if (accept) begin
      act    <= (len_in != '0);
      len_q  <= len_in;
      idx_q  <= '0;
      addr_q <= base;
      step_q <= stride;
    end else begin
      if (go) begin
        addr_q <= addr_q + step_q;
        idx_q  <= idx_q + VLW'(1);
      end
      if (last_rsp) act <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_vld  <= 1'b0;
      mem_bank <= '0;
      mem_row  <= '0;
      mem_elem <= '0;
    end else begin
      mem_vld <= go;
      if (go) begin
        mem_bank <= cur_bank;
        mem_row  <= addr_q[AW-1:BANK_BITS];
        mem_elem <= idx_q[IW-1:0];
      end
    end
  end

  genvar s;
  generate
    for (s = 0; s < LAT; s++) begin : g_lat
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pv[s]   <= 1'b0;
          pidx[s] <= '0;
        end else if (s == 0) begin
          pv[s]   <= mem_vld;
          pidx[s] <= mem_elem;
        end else begin
          pv[s]   <= pv[(s == 0) ? 0 : s-1];
          pidx[s] <= pidx[(s == 0) ? 0 : s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_vld  <= 1'b0;
      rsp_idx  <= '0;
      rsp_data <= '0;
      done     <= 1'b0;
    end else begin
      rsp_vld <= pv[LAT-1];
      if (pv[LAT-1]) begin
        rsp_idx  <= pidx[LAT-1];
        rsp_data <= mem_rdata;
      end
      done <= last_rsp || (accept && len_in == '0);
    end
  end

  AST_BANK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |=> !(mem_vld && mem_bank == $past(mem_bank)));  // R3
  AST_ISSUE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    mem_vld |=> (!mem_vld || mem_elem == $past(mem_elem) + IW'(1)));  // R4
  AST_RSP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |=> (!rsp_vld || rsp_idx == $past(rsp_idx) + IW'(1)));  // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !act && vlen == '0) |=> (done && !mem_vld));  // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> !mem_vld);  // R11
endmodule

// File: tb/sim_vec_stride_agu.sv
module sim_vec_stride_agu;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [15:0] base = '0, stride = '0;
  logic [6:0]  vlen = '0;
  logic mem_vld, rsp_vld, done;
  logic [3:0]  mem_bank;
  logic [11:0] mem_row;
  logic [5:0]  mem_elem, rsp_idx;
  logic [31:0] mem_rdata = '0, rsp_data;

  vec_stride_agu u0 (.clk(clk), .rst_n(rst_n), .start(start), .base(base), .stride(stride),
    .vlen(vlen), .mem_vld(mem_vld), .mem_bank(mem_bank), .mem_row(mem_row), .mem_elem(mem_elem),
    .mem_rdata(mem_rdata), .rsp_vld(rsp_vld), .rsp_idx(rsp_idx), .rsp_data(rsp_data), .done(done));

  always #10 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  int nissue, nrsp, ndone, done_t, last_rsp_t;
  int itime [64];
  int bank_t [16];
  logic [15:0] cb, cs;
  logic [15:0] ring_a [16];
  bit          ring_v [16];

  localparam logic [47:0] VEC [8] = '{
    {16'h0100, 16'h0001, 8'd16,  8'd1},
    {16'h0203, 16'h0010, 8'd8,   8'd2},
    {16'h0010, 16'h0003, 8'd64,  8'd1},
    {16'h1234, 16'h0002, 8'd20,  8'd1},
    {16'h0005, 16'h0004, 8'd12,  8'd1},
    {16'h0007, 16'h0008, 8'd10,  8'd0},
    {16'hFFF0, 16'hFFF0, 8'd5,   8'd2},
    {16'h00A0, 16'h0005, 8'd100, 8'd1}
  };

  function automatic logic [15:0] ea(int i);
    return 16'(cb + 16'(i) * cs);
  endfunction
  function automatic logic [31:0] fdat(logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    for (int k = 0; k < 16; k++) begin ring_v[k] = 0; ring_a[k] = '0; bank_t[k] = -100; end
  end

  always @(negedge clk) begin
    mem_rdata = ring_v[(cyc+4)%16] ? fdat(ring_a[(cyc+4)%16]) : 32'h0;
    ring_v[cyc%16] = mem_vld;
    ring_a[cyc%16] = {mem_row, mem_bank};
    if (rst_n && mem_vld) begin
      chk(mem_elem == 6'(nissue), "R4", mem_elem, nissue);
      chk({mem_row, mem_bank} == ea(nissue), "R1", {mem_row, mem_bank}, ea(nissue));
      chk(mem_bank == ea(nissue)[3:0], "R2", mem_bank, ea(nissue)[3:0]);
      chk(cyc - bank_t[mem_bank] >= 4, "R3", cyc - bank_t[mem_bank], 4);
      bank_t[mem_bank] = cyc;
      if (nissue < 64) itime[nissue] = cyc;
      nissue++;
    end
    if (rst_n && rsp_vld) begin
      chk(rsp_idx == 6'(nrsp), "R7", rsp_idx, nrsp);
      chk(rsp_data == fdat(ea(nrsp)), "R7", rsp_data, fdat(ea(nrsp)));
      chk(cyc == itime[nrsp % 64] + 13, "R7", cyc, itime[nrsp % 64] + 13);
      nrsp++;
      last_rsp_t = cyc;
    end
    if (rst_n && done) begin
      ndone++;
      done_t = cyc;
    end
  end

  task automatic run_vec(logic [15:0] b, logic [15:0] s, int l, int kind, bit poke);
    int t0, expn;
    cb = b; cs = s; nissue = 0; nrsp = 0; ndone = 0; done_t = -1; last_rsp_t = -1;
    expn = (l > 64) ? 64 : l;
    @(negedge clk);
    base = b; stride = s; vlen = 7'(l); start = 1'b1;
    @(posedge clk); #1; t0 = cyc;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      base = 16'h4000; stride = 16'h0007; vlen = 7'd3; start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    for (int w = 0; w < 2000 && ndone == 0; w++) @(negedge clk);
    @(negedge clk);
    chk(ndone == 1, "R9", ndone, 1);
    chk(nissue == expn, "R8", nissue, expn);
    chk(nrsp == expn, "R8", nrsp, expn);
    if (expn == 0) chk(done_t == t0, "R10", done_t, t0);
    else           chk(done_t == last_rsp_t, "R9", done_t, last_rsp_t);
    if (kind == 1)
      for (int i = 1; i < expn; i++) chk(itime[i] == itime[0] + i, "R5", itime[i], itime[0] + i);
    if (kind == 2)
      for (int i = 1; i < expn; i++) chk(itime[i] == itime[0] + 4*i, "R6", itime[i], itime[0] + 4*i);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!mem_vld && !rsp_vld && !done, "R12", {mem_vld, rsp_vld, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_vld && !rsp_vld && !done, "R12", {mem_vld, rsp_vld, done}, 0);
    for (int v = 0; v < 8; v++)
      run_vec(VEC[v][47:32], VEC[v][31:16], int'(VEC[v][15:8]), int'(VEC[v][7:0]), 1'b0);
    run_vec(16'h0300, 16'h0001, 0, 0, 1'b0);                // R10 zero length
    run_vec(16'h0500, 16'h0001, 24, 1, 1'b1);               // R11 start while busy ignored
    run_vec(16'h0001, 16'h0020, 1, 0, 1'b0);                // single element
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=finish", cyc);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule